// File: doc/BRIEF.md
# Line 21 Closed Caption Inserter

This block places two caption bytes per field onto line 21 of an interlaced timing stream. It follows the active line number and the field flag and counts sample strobes from the start of each line. On line 21 of a field that the 2-bit mode selects, it sends a serial pattern with four parts in order:

- an alternating clock run-in;
- a three-bit start code;
- the first data byte;
- the second data byte.

Each data byte is seven data bits, LSB first, followed by a generated odd-parity bit. On every other line and field the serial output stays at the idle (blank) level of 0. Turning the bits into an analog level and shaping the waveform are left to the stages after this block.

Software writes the two byte inputs at any time. The block copies them into a shadow pair at the start of each line that is going to carry captions. A write that lands during a transmission therefore only takes effect in the next enabled field. When the last bit of the frame has been sent, the block raises a one-clock "taken" pulse so that software can write the next pair of bytes.

The bit period is a programmable number of sample strobes. The first run-in bit starts at a programmable sample offset from the start of the line. A new line begins at the first strobe whose line number differs from the line number at the previous strobe. That strobe is sample 0 of the line.

Top module: `cc21_inserter`

## Requirements
- R1: After reset, and whenever no frame is being sent, `cc_data`, `cc_gate` and `cc_taken` are 0. With `cc_mode` = 00, no frame is ever sent.
- R2: `cc_mode` selects the fields. 01 sends only when `field_even` = 0 (field 1, odd). 10 sends only when `field_even` = 1 (field 2, even). 11 sends in both fields. The mode and the field are sampled at the line-start strobe.
- R3: A frame is sent only on the line whose number equals the parameter CC_LINE (default 21).
- R4: A frame is 33 bits long. Frame bits 0 to 13 form the run-in 1,0,1,0,…,0, starting with 1. Frame bits 14, 15 and 16 form the start code 0,0,1.
- R5: Frame bits 17 to 23 are `byte_a[0]` to `byte_a[6]`. Bit 24 is the parity bit that makes the number of ones in bits 17 to 24 odd. Bits 25 to 32 carry `byte_b` and its parity bit in the same way.
- R6: Each frame bit is held for `bit_period` strobes (`bit_period` ≥ 1). The outputs change only on a clock with `smp_stb` high, except `cc_taken`, which falls on the next clock.
- R7: Frame bit k is presented after the strobes of samples `start_ofs` + k·`bit_period` to `start_ofs` + (k+1)·`bit_period` − 1. Sample 0 is the line-start strobe.
- R8: `cc_gate` is 1 exactly while a frame bit is being presented, and `cc_data` then carries that bit.
- R9: `cc_taken` is a one-clock pulse that follows the strobe of sample `start_ofs` + 33·`bit_period`.
- R10: The bytes sent are the values on `byte_a` and `byte_b` at the line-start strobe of the enabled line. Changes to these inputs later in that line have no effect until the next enabled line.
- R11: If a new line starts before the frame ends, the frame is dropped. The outputs return to idle on that strobe and no `cc_taken` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe; one pulse per video sample |
| line_num | input | LINE_W | Current line number |
| field_even | input | 1 | 0 = field 1 (odd), 1 = field 2 (even) |
| cc_mode | input | 2 | Field selection code |
| byte_a | input | 7 | First caption byte (data bits only) |
| byte_b | input | 7 | Second caption byte (data bits only) |
| bit_period | input | DIV_W | Strobes per frame bit |
| start_ofs | input | OFS_W | Sample at which the run-in starts |
| cc_data | output | 1 | Serial caption bit, 0 when idle |
| cc_gate | output | 1 | High while a frame bit is presented |
| cc_taken | output | 1 | One-clock pulse after a frame completes |

## Verification
Every combination of mode code and field is run on line 21 and on the lines next to it. This separates the field decode from the line match. The bit period is swept from 1 to 4 and the offset over 0, 1 and 7, and the byte values change from frame to frame. This exposes off-by-one errors in bit length, bit order, start position and parity. Each expected sample comes from the arithmetic formula for the bit index, frame[(s − offset) / period]. One test changes the bytes in the middle of a line, which separates shadowed bytes from live ones. Another ends a line early, which shows that a dropped frame sends no "taken" pulse.

// File: rtl/cc21_pkg.sv
package cc21_pkg;
    localparam int RUNIN_BITS = 14;
    localparam int START_BITS = 3;
    localparam int DATA_BITS  = 7;
    localparam int BYTE_BITS  = DATA_BITS + 1;
    localparam int FRAME_BITS = RUNIN_BITS + START_BITS + 2 * BYTE_BITS;
    localparam int BIDX_W     = $clog2(FRAME_BITS);
    localparam logic [START_BITS-1:0] START_CODE = 3'b100; // sent LSB first: 0,0,1

    function automatic logic odd_par(input logic [DATA_BITS-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/cc21_field_gate.sv
module cc21_field_gate (
    input  logic [1:0] mode,
    input  logic       field_even,
    output logic       enable
);
    always_comb begin
        enable = field_even ? mode[1] : mode[0];
    end
endmodule

// File: rtl/cc21_line_edge.sv
module cc21_line_edge #(
    parameter int LINE_W = 10
) (
    input  logic [LINE_W-1:0] line_now,
    input  logic [LINE_W-1:0] line_prev,
    input  logic              seen,
    output logic              new_line
);
    always_comb begin
        new_line = !seen || (line_now != line_prev);
    end
endmodule

// File: rtl/cc21_frame_pack.sv
module cc21_frame_pack
    import cc21_pkg::*;
(
    input  logic [DATA_BITS-1:0]  first_b,
    input  logic [DATA_BITS-1:0]  second_b,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int A_LO = RUNIN_BITS + START_BITS;
    localparam int B_LO = A_LO + BYTE_BITS;

    for (genvar g = 0; g < RUNIN_BITS; g++) begin : g_runin
        assign frame[g] = ((g % 2) == 0) ? 1'b1 : 1'b0;
    end

    assign frame[RUNIN_BITS +: START_BITS] = START_CODE;
    assign frame[A_LO +: DATA_BITS]        = first_b;
    assign frame[A_LO + DATA_BITS]         = odd_par(first_b);
    assign frame[B_LO +: DATA_BITS]        = second_b;
    assign frame[B_LO + DATA_BITS]         = odd_par(second_b);
endmodule

// File: rtl/cc21_inserter.sv
module cc21_inserter
    import cc21_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int CC_LINE = 21,
    parameter int DIV_W   = 8,
    parameter int OFS_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_even,
    input  logic [1:0]        cc_mode,
    input  logic [6:0]        byte_a,
    input  logic [6:0]        byte_b,
    input  logic [DIV_W-1:0]  bit_period,
    input  logic [OFS_W-1:0]  start_ofs,
    output logic              cc_data,
    output logic              cc_gate,
    output logic              cc_taken
);
    localparam int SC_W = OFS_W + 1;
    localparam logic [SC_W-1:0]   SC_MAX   = '1;
    localparam logic [LINE_W-1:0] LINE_SEL = LINE_W'(CC_LINE);
    localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [LINE_W-1:0]    line;
        logic                 seen;
        logic [SC_W-1:0]      samp;
        logic                 armed;
        logic                 tx;
        logic [BIDX_W-1:0]    bidx;
        logic [DIV_W-1:0]     div;
        logic [DATA_BITS-1:0] sh_a;
        logic [DATA_BITS-1:0] sh_b;
        logic                 data;
        logic                 gate;
        logic                 taken;
    } st_t;

    st_t st_d, st_q;

    logic                  field_ok;
    logic                  new_line;
    logic                  load_sh;
    logic [DATA_BITS-1:0]  nx_a, nx_b;
    logic [FRAME_BITS-1:0] frame;
    logic [DIV_W-1:0]      per_m1;

    cc21_field_gate u_fgate (
        .mode       (cc_mode),
        .field_even (field_even),
        .enable     (field_ok)
    );

    cc21_line_edge #(.LINE_W(LINE_W)) u_ledge (
        .line_now  (line_num),
        .line_prev (st_q.line),
        .seen      (st_q.seen),
        .new_line  (new_line)
    );

    assign load_sh = smp_stb && new_line && field_ok && (line_num == LINE_SEL);
    assign nx_a    = load_sh ? byte_a : st_q.sh_a;
    assign nx_b    = load_sh ? byte_b : st_q.sh_b;
    assign per_m1  = (bit_period == '0) ? '0 : bit_period - 1'b1;

    cc21_frame_pack u_pack (
        .first_b  (nx_a),
        .second_b (nx_b),
        .frame    (frame)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.sh_a  = nx_a;
        st_d.sh_b  = nx_b;
        if (smp_stb) begin
            st_d.line = line_num;
            st_d.seen = 1'b1;
            if (new_line) begin
                st_d.samp  = '0;
                st_d.armed = load_sh;
                st_d.tx    = 1'b0;
            end else if (st_q.samp != SC_MAX) begin
                st_d.samp = st_q.samp + 1'b1;
            end

            if (st_d.armed && (st_d.samp == {1'b0, start_ofs})) begin
                st_d.armed = 1'b0;
                st_d.tx    = 1'b1;
                st_d.bidx  = '0;
                st_d.div   = '0;
            end else if (st_q.tx && !new_line) begin
                if (st_q.div >= per_m1) begin
                    st_d.div = '0;
                    if (st_q.bidx == LAST_BIT) begin
                        st_d.tx    = 1'b0;
                        st_d.taken = 1'b1;
                    end else begin
                        st_d.bidx = st_q.bidx + 1'b1;
                    end
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end

            st_d.gate = st_d.tx;
            st_d.data = st_d.tx ? frame[st_d.bidx] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_data  = st_q.data;
    assign cc_gate  = st_q.gate;
    assign cc_taken = st_q.taken;
endmodule

// File: rtl/cc21_inserter_chk.sv
module cc21_inserter_chk #(
    parameter int LINE_W  = 10,
    parameter int CC_LINE = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_stb,
    input logic [LINE_W-1:0] line_num,
    input logic              cc_data,
    input logic              cc_gate,
    input logic              cc_taken
);
    localparam logic [LINE_W-1:0] LINE_SEL = LINE_W'(CC_LINE);

    // R9: the completion pulse lasts a single clock
    p_taken_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cc_taken |=> !cc_taken);

    // R9: the pulse follows the end of a frame window
    p_taken_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_taken) |-> ($past(cc_gate) && !cc_gate));

    // R6: outputs hold when no strobe arrives
    p_hold_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(cc_data) && $stable(cc_gate)));

    // R3: a frame only opens on the caption line
    p_gate_on_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_gate) |-> ($past(line_num) == LINE_SEL));

    // R4: the first run-in bit is a one
    p_first_bit_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_gate) |-> cc_data);
endmodule

bind cc21_inserter cc21_inserter_chk #(.LINE_W(LINE_W), .CC_LINE(CC_LINE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .line_num (line_num),
    .cc_data  (cc_data),
    .cc_gate  (cc_gate),
    .cc_taken (cc_taken)
);

// File: tb/cc21_inserter_tb.sv
module cc21_inserter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [9:0] line_num = 10'd300;
    logic       field_even = 1'b0;
    logic [1:0] cc_mode = 2'b00;
    logic [6:0] byte_a = 7'h00;
    logic [6:0] byte_b = 7'h00;
    logic [7:0] bit_period = 8'd1;
    logic [9:0] start_ofs = 10'd0;
    logic       cc_data, cc_gate, cc_taken;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cc21_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .line_num(line_num),
        .field_even(field_even), .cc_mode(cc_mode), .byte_a(byte_a), .byte_b(byte_b),
        .bit_period(bit_period), .start_ofs(start_ofs),
        .cc_data(cc_data), .cc_gate(cc_gate), .cc_taken(cc_taken)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
        end
    endtask

    // Expected frame bit per R4/R5, derived from the bit index
    function automatic logic fbit(input int i, input logic [6:0] a, input logic [6:0] b);
        int ones;
        logic [6:0] v;
        if (i < 14) return (i % 2 == 0);
        if (i < 16) return 1'b0;
        if (i == 16) return 1'b1;
        v = (i < 25) ? a : b;
        if (i == 24 || i == 32) begin
            ones = 0;
            for (int k = 0; k < 7; k++) ones += v[k];
            return (ones % 2 == 0);
        end
        return v[(i < 25) ? i - 17 : i - 25];
    endfunction

    // One line: len strobes, each followed by a quiet clock
    task automatic run_line(input int ln, input logic fe, input logic [1:0] md,
                            input logic [6:0] a, input logic [6:0] b,
                            input int per, input int ofs, input int len,
                            input int mid_at, input logic [6:0] ma, input logic [6:0] mb);
        bit sel;
        int stop;
        logic ed, eg, et;
        sel  = (ln == 21) && (fe ? md[1] : md[0]);
        stop = ofs + 33 * per;
        bit_period = 8'(per);
        start_ofs  = 10'(ofs);
        for (int s = 0; s < len; s++) begin
            line_num   = 10'(ln);
            field_even = fe;
            cc_mode    = md;
            if (s == 0) begin byte_a = a; byte_b = b; end
            if (s == mid_at) begin byte_a = ma; byte_b = mb; end
            smp_stb = 1'b1;
            @(posedge clk);
            @(negedge clk);
            eg = sel && (s >= ofs) && (s < stop);
            ed = eg ? fbit((s - ofs) / per, a, b) : 1'b0;
            et = sel && (s == stop);
            chk(cc_gate,  eg, $sformatf("R8/R7 gate ln=%0d fe=%0d md=%0d s=%0d", ln, fe, md, s));
            chk(cc_data,  ed, $sformatf("R4/R5/R6 data ln=%0d fe=%0d md=%0d per=%0d s=%0d", ln, fe, md, per, s));
            chk(cc_taken, et, $sformatf("R9 taken ln=%0d s=%0d", ln, s));
            smp_stb = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(cc_gate,  eg, "R6 gate hold");
            chk(cc_data,  ed, "R6 data hold");
            chk(cc_taken, 1'b0, "R9 taken single clock");
        end
    endtask

    task automatic sep();
        run_line(300, 1'b0, 2'b11, 7'h00, 7'h00, 1, 0, 2, -1, 7'h00, 7'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cc_data, 1'b0, "R1 reset data");
        chk(cc_gate, 1'b0, "R1 reset gate");
        chk(cc_taken, 1'b0, "R1 reset taken");
        rst_n = 1'b1;

        // R1 R2 R3: every mode, both fields, around the caption line
        for (int md = 0; md < 4; md++)
            for (int fe = 0; fe < 2; fe++)
                for (int ln = 20; ln <= 22; ln++) begin
                    sep();
                    run_line(ln, fe[0], md[1:0], 7'(md * 37 + ln), 7'(fe * 51 + 9),
                             2, 3, 3 + 66 + 3, -1, 7'h00, 7'h00);
                end

        // R5 R6 R7: bit period and offset sweep
        for (int per = 1; per <= 4; per++)
            for (int oi = 0; oi < 3; oi++) begin
                int ofs;
                ofs = (oi == 2) ? 7 : oi;
                sep();
                run_line(21, per[0], 2'b11, 7'(per * 29 + oi * 5), 7'(127 - per * 13 - oi),
                         per, ofs, ofs + 33 * per + 2, -1, 7'h00, 7'h00);
            end

        // R5 parity corners: all zeros and all ones
        sep();
        run_line(21, 1'b0, 2'b01, 7'h00, 7'h7F, 1, 2, 37, -1, 7'h00, 7'h00);

        // R10: mid-line writes ignored, used on next enabled line
        sep();
        run_line(21, 1'b0, 2'b11, 7'h15, 7'h6A, 2, 1, 70, 10, 7'h33, 7'h4C);
        sep();
        run_line(21, 1'b1, 2'b11, 7'h33, 7'h4C, 2, 1, 70, -1, 7'h00, 7'h00);

        // R11: line ends mid-frame, frame dropped, no pulse
        sep();
        run_line(21, 1'b0, 2'b01, 7'h55, 7'h2A, 3, 4, 20, -1, 7'h00, 7'h00);
        sep();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule